// File: doc/BRIEF.md
# Bus Hold and Priority Arbiter

This block decides which of three requesters owns an external memory bus: an outside master that asks through an active-low hold request and is answered with an active-low acknowledge, a DMA controller, and the CPU. Priority is fixed. The outside master wins over DMA, and DMA wins over the CPU. Ownership moves only at an access boundary, which is any clock edge at which the bus cycle engine reports no access in progress. An access that has already started always runs to completion.

The hold request is asynchronous, so it passes through a synchronizer before it is used. While the outside master owns the bus, the block drives low the output enables for the address, data, read/write strobe, chip-select and byte-high-enable pads, which lets those pins float. In the same state it drives the acknowledge low and raises a pause signal for the watchdog timer. Other peripherals are not affected. The level of the address-latch-enable pin during hold is left undefined, and this block does not produce it.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While `rst_n` is low and after any reset, the CPU holds the grant, `hold_ack_n_o` is 1, every output enable is 1 and `wdt_pause_o` is 0.
- R2: Exactly one of `grant_cpu_o`, `grant_dma_o` and `grant_ext_o` is 1 in every cycle.
- R3: When `bus_busy_i` is 1 at a rising edge, none of the grants changes at that edge.
- R4: At each rising edge where `bus_busy_i` is 0, ownership goes to the outside master if its synchronized request is active. Otherwise it goes to DMA if `dma_req_i` is 1. Otherwise it goes to the CPU.
- R5: `hold_req_n_i` passes through SYNC_STAGES (default 2) flops. With `bus_busy_i` at 0, a low level on it sets `grant_ext_o` at the third rising edge after the level is applied, and not before.
- R6: `hold_ack_n_o` is 0 exactly in the cycles where `grant_ext_o` is 1. It stays 0 as long as the request stays low.
- R7: While `grant_ext_o` is 1, `addr_oe_o`, `strobe_oe_o`, `bhe_oe_o`, every bit of `data_oe_o` and every bit of `cs_oe_o` are 0. In all other cycles they are 1.
- R8: `wdt_pause_o` is 1 exactly in the cycles where `grant_ext_o` is 1.
- R9: After `hold_req_n_i` returns high, ownership goes back at the first boundary that follows the synchronizer delay. It goes to DMA if `dma_req_i` is 1 and to the CPU otherwise.
- R10: If the CPU owns the bus and `dma_req_i` is 1, DMA takes the bus at the first rising edge where `bus_busy_i` is 0, and not during the busy cycles before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_req_n_i | input | 1 | Asynchronous active-low hold request from the outside master |
| dma_req_i | input | 1 | DMA controller wants the bus |
| bus_busy_i | input | 1 | A bus access is in progress, so ownership must not change |
| grant_cpu_o | output | 1 | CPU owns the bus |
| grant_dma_o | output | 1 | DMA owns the bus |
| grant_ext_o | output | 1 | Outside master owns the bus |
| hold_ack_n_o | output | 1 | Active-low hold acknowledge |
| addr_oe_o | output | 1 | Address pad output enable |
| data_oe_o | output | DATA_LANES | Data pad output enable, one bit per byte lane |
| strobe_oe_o | output | 1 | Read/write strobe pad output enable |
| cs_oe_o | output | CS_W | Chip-select pad output enables |
| bhe_oe_o | output | 1 | Byte-high-enable pad output enable |
| wdt_pause_o | output | 1 | Stops the watchdog timer while the hold is granted |

## Verification
The assertions check on every cycle that exactly one grant is active and that grants stay frozen across busy edges. They also check that the acknowledge, the pad enables and the watchdog pause follow the external grant, and that the priority choice is made whenever the bus is idle. Only the bench scenarios can show the exact synchronizer latency of the asynchronous request and the order of the hand-back when the hold ends. The same applies to a DMA request that waits out a long CPU access. The bench covers these with directed sequences and with a long pseudo-random sweep over all eight input combinations, checked against an arithmetic model.

// File: rtl/bha_pkg.sv
// Package: shared owner encoding and the fixed priority choice.
// Assumes: three requesters only; the outside master ranks highest.
package bha_pkg;

    typedef enum logic [1:0] {
        OWN_CPU = 2'd0,
        OWN_DMA = 2'd1,
        OWN_EXT = 2'd2
    } owner_e;

    localparam int NUM_OWNERS = 3;

    // Fixed priority: outside master, then DMA, then CPU.
    function automatic owner_e pick_owner(input logic ext_req, input logic dma_req);
        owner_e o;
        if (ext_req)      o = OWN_EXT;
        else if (dma_req) o = OWN_DMA;
        else              o = OWN_CPU;
        return o;
    endfunction

    // One-hot grant vector: bit 0 CPU, bit 1 DMA, bit 2 outside master.
    function automatic logic [NUM_OWNERS-1:0] owner_onehot(input owner_e o);
        logic [NUM_OWNERS-1:0] v;
        v = '0;
        v[o] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/bha_sync.sv
// Module: multi-flop synchronizer for the asynchronous active-low hold request.
// Produces an active-high synchronized request.
// Assumes: the input may change at any time; STAGES >= 2.
module bha_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n_i,
    output logic req_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the chain; reset to released (high).
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_n_i};
    end

    assign req_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/bha_select.sv
// Module: owner register with boundary-gated update and registered one-hot grants.
// Assumes: bus_busy_i is synchronous and high for every cycle of an access.
module bha_select
    import bha_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ext_req_i,
    input  logic                  dma_req_i,
    input  logic                  bus_busy_i,
    output owner_e                owner_nxt_o,
    output logic [NUM_OWNERS-1:0] grant_o
);
    owner_e owner_q;

    // Next owner: hold the current one mid-access, else choose by priority.
    always_comb begin
        if (bus_busy_i) owner_nxt_o = owner_q;
        else            owner_nxt_o = pick_owner(ext_req_i, dma_req_i);
    end

    // Owner state and its one-hot grant outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= OWN_CPU;
            grant_o <= owner_onehot(OWN_CPU);
        end else begin
            owner_q <= owner_nxt_o;
            grant_o <= owner_onehot(owner_nxt_o);
        end
    end

    // R2
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(grant_o));

    // R3
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_busy_i |=> $stable(grant_o));

endmodule

// File: rtl/bha_pins.sv
// Module: registered pad-enable, acknowledge and watchdog-pause outputs.
// All are released while the outside master owns the bus.
// Assumes: owner_nxt_i is the owner for the coming cycle.
module bha_pins
    import bha_pkg::*;
#(
    parameter int CS_W       = 4,
    parameter int DATA_LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  owner_e                owner_nxt_i,
    output logic                  hold_ack_n_o,
    output logic                  addr_oe_o,
    output logic [DATA_LANES-1:0] data_oe_o,
    output logic                  strobe_oe_o,
    output logic [CS_W-1:0]       cs_oe_o,
    output logic                  bhe_oe_o,
    output logic                  wdt_pause_o
);
    logic drive_nxt;

    // Pads are driven by the chip unless the outside master is taking over.
    always_comb drive_nxt = (owner_nxt_i != OWN_EXT);

    // Control outputs: acknowledge, watchdog pause and single-bit enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_ack_n_o <= 1'b1;
            wdt_pause_o  <= 1'b0;
            addr_oe_o    <= 1'b1;
            strobe_oe_o  <= 1'b1;
            bhe_oe_o     <= 1'b1;
        end else begin
            hold_ack_n_o <= drive_nxt;
            wdt_pause_o  <= ~drive_nxt;
            addr_oe_o    <= drive_nxt;
            strobe_oe_o  <= drive_nxt;
            bhe_oe_o     <= drive_nxt;
        end
    end

    for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
        // One enable flop per data byte lane.
        always_ff @(posedge clk) begin
            if (!rst_n) data_oe_o[l] <= 1'b1;
            else        data_oe_o[l] <= drive_nxt;
        end
    end

    for (genvar c = 0; c < CS_W; c++) begin : g_cs
        // One enable flop per chip-select pad.
        always_ff @(posedge clk) begin
            if (!rst_n) cs_oe_o[c] <= 1'b1;
            else        cs_oe_o[c] <= drive_nxt;
        end
    end

    // R8
    wdt_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_pause_o == ~hold_ack_n_o);

endmodule

// File: rtl/bus_hold_arbiter.sv
// Module: top of the bus ownership arbiter (outside hold > DMA > CPU).
// Ownership changes only at idle bus edges. Pads float during hold.
// Assumes: bus_busy_i comes from the bus cycle engine in this clock domain.
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CS_W        = 4,
    parameter int DATA_LANES  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hold_req_n_i,
    input  logic                  dma_req_i,
    input  logic                  bus_busy_i,
    output logic                  grant_cpu_o,
    output logic                  grant_dma_o,
    output logic                  grant_ext_o,
    output logic                  hold_ack_n_o,
    output logic                  addr_oe_o,
    output logic [DATA_LANES-1:0] data_oe_o,
    output logic                  strobe_oe_o,
    output logic [CS_W-1:0]       cs_oe_o,
    output logic                  bhe_oe_o,
    output logic                  wdt_pause_o
);
    logic                  ext_req;
    owner_e                owner_nxt;
    logic [NUM_OWNERS-1:0] grant;

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_n_i (hold_req_n_i),
        .req_o     (ext_req)
    );

    bha_select u_select (
        .clk         (clk),
        .rst_n       (rst_n),
        .ext_req_i   (ext_req),
        .dma_req_i   (dma_req_i),
        .bus_busy_i  (bus_busy_i),
        .owner_nxt_o (owner_nxt),
        .grant_o     (grant)
    );

    bha_pins #(.CS_W(CS_W), .DATA_LANES(DATA_LANES)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .owner_nxt_i  (owner_nxt),
        .hold_ack_n_o (hold_ack_n_o),
        .addr_oe_o    (addr_oe_o),
        .data_oe_o    (data_oe_o),
        .strobe_oe_o  (strobe_oe_o),
        .cs_oe_o      (cs_oe_o),
        .bhe_oe_o     (bhe_oe_o),
        .wdt_pause_o  (wdt_pause_o)
    );

    assign grant_cpu_o = grant[OWN_CPU];
    assign grant_dma_o = grant[OWN_DMA];
    assign grant_ext_o = grant[OWN_EXT];

    // R6
    ack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack_n_o == ~grant_ext_o);

    // R7
    pads_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_ext_o |-> !(addr_oe_o | strobe_oe_o | bhe_oe_o | (|data_oe_o) | (|cs_oe_o)));

    // R4
    ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy_i && ext_req) |=> grant_ext_o);

    // R10
    dma_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_busy_i && !ext_req && dma_req_i) |=> grant_dma_o);

endmodule

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
    localparam int CS_W = 4;
    localparam int DL   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hold_n = 1'b1;
    logic dma = 1'b0;
    logic busy = 1'b0;
    logic g_cpu, g_dma, g_ext, ack_n, a_oe, s_oe, b_oe, wdt;
    logic [DL-1:0]   d_oe;
    logic [CS_W-1:0] c_oe;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference state: two sync flops and owner (0 CPU, 1 DMA, 2 ext).
    logic m_s1 = 1'b1, m_s2 = 1'b1;
    int   m_own = 0;

    always #5 clk = ~clk;

    bus_hold_arbiter #(.SYNC_STAGES(2), .CS_W(CS_W), .DATA_LANES(DL)) dut_i (
        .clk(clk), .rst_n(rst_n), .hold_req_n_i(hold_n), .dma_req_i(dma),
        .bus_busy_i(busy), .grant_cpu_o(g_cpu), .grant_dma_o(g_dma),
        .grant_ext_o(g_ext), .hold_ack_n_o(ack_n), .addr_oe_o(a_oe),
        .data_oe_o(d_oe), .strobe_oe_o(s_oe), .cs_oe_o(c_oe),
        .bhe_oe_o(b_oe), .wdt_pause_o(wdt)
    );

    // Arithmetic model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_own <= 0;
        end else begin
            m_s1 <= hold_n;
            m_s2 <= m_s1;
            if (!busy) m_own <= (!m_s2) ? 2 : (dma ? 1 : 0);
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic chk_all();
        logic ext;
        ext = (m_own == 2);
        chk({29'd0, g_ext, g_dma, g_cpu}, 32'd1 << m_own, "R4 grants");
        chk(32'(g_cpu) + 32'(g_dma) + 32'(g_ext), 32'd1, "R2 onehot");
        chk({31'd0, ack_n}, {31'd0, ~ext}, "R6 ack");
        chk({28'd0, a_oe, s_oe, b_oe, &d_oe}, {28'd0, {4{~ext}}}, "R7 oe");
        chk({28'd0, |d_oe, |c_oe, &c_oe, 1'b0}, {28'd0, ~ext, ~ext, ~ext, 1'b0}, "R7 oe vec");
        chk({31'd0, wdt}, {31'd0, ext}, "R8 wdt");
    endtask

    task automatic step(input logic h, input logic d, input logic b);
        hold_n = h; dma = d; busy = b;
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk({31'd0, g_cpu}, 32'd1, "R1 cpu");
        chk({31'd0, ack_n}, 32'd1, "R1 ack");
        chk({31'd0, wdt}, 32'd0, "R1 wdt");
        chk_all();
        rst_n = 1'b1;
        @(negedge clk);

        // R5: latency of the hold request with the bus idle
        step(1'b0, 1'b0, 1'b0);
        chk({31'd0, g_ext}, 32'd0, "R5 edge1");
        step(1'b0, 1'b0, 1'b0);
        chk({31'd0, g_ext}, 32'd0, "R5 edge2");
        step(1'b0, 1'b0, 1'b0);
        chk({31'd0, g_ext}, 32'd1, "R5 edge3");
        chk_all();
        // R6: acknowledge held while the request stays low
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1, 1'b0);
            chk({31'd0, ack_n}, 32'd0, "R6 held");
        end
        // R9: release with DMA waiting hands the bus to DMA
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        chk({31'd0, g_ext}, 32'd1, "R9 still ext");
        step(1'b1, 1'b1, 1'b0);
        chk({31'd0, g_dma}, 32'd1, "R9 to dma");
        chk_all();
        step(1'b1, 1'b0, 1'b0);
        chk({31'd0, g_cpu}, 32'd1, "R4 back cpu");

        // R10 and R3: DMA waits out a long CPU access
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, 1'b1);
            chk({31'd0, g_cpu}, 32'd1, "R3 busy hold cpu");
        end
        step(1'b1, 1'b1, 1'b0);
        chk({31'd0, g_dma}, 32'd1, "R10 dma at boundary");

        // R3/R5: hold request during busy waits for the boundary
        for (int i = 0; i < 6; i++) begin
            step(1'b0, 1'b1, 1'b1);
            chk({31'd0, g_dma}, 32'd1, "R3 busy hold dma");
        end
        step(1'b0, 1'b1, 1'b0);
        chk({31'd0, g_ext}, 32'd1, "R5 after access");
        chk_all();

        // Sweep all input combinations from an LFSR, checked each cycle.
        lfsr = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(n[7] ? lfsr[0] : (lfsr[0] & lfsr[5]), lfsr[3], lfsr[6] & lfsr[9]);
            chk_all();
        end

        // R1: reset again from a hold state
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        chk({31'd0, g_cpu}, 32'd1, "R1 re-reset cpu");
        chk_all();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule